// File: doc/BRIEF.md
# Incremental Memory Scrub Engine

This block stops single-bit upsets from building up in a RAM that sits behind an error-correcting encoder and decoder. Each scrub tick, typically from a periodic interrupt, makes the engine claim the memory bus. It reads one word through the correcting read path and writes the returned word straight back to the same address. Because the write goes through the normal encoder, the corrected data and newly generated check bits replace the damaged word. A single upset is therefore cleared before a second one can land in the same word and make it uncorrectable.

The scrub pointer walks a fixed address window one word at a time and wraps from the top of the window back to its base. The engine raises a bus request and acts only when the external arbiter grants it. The CPU always has priority for a grant that is not yet given. Once granted, the engine keeps its request up until its write-back is done, so a read and its write-back are never separated by a CPU cycle. A tick that arrives while a scrub is still running is remembered as one pending tick. Each time the pointer wraps, the engine gives a one-cycle pulse and increments a pass counter.

Top module: `mem_scrub_engine`

## Requirements
- R1: After reset, bus_req_o, mem_rd_o, mem_wr_o and pass_done_o are 0, pass_count_o is 0, and the first address scrubbed is REGION_LO.
- R2: Each served tick gives exactly one read strobe (mem_rd_o high for one cycle). After the read data returns (mem_rvalid_i high), it gives exactly one write strobe to the same address, and mem_wdata_o equals the returned data.
- R3: Successive scrubs visit REGION_LO, REGION_LO+1, … up to REGION_HI, then continue again from REGION_LO.
- R4: pass_done_o is high for exactly the one cycle after the write strobe to REGION_HI. pass_count_o increments by one in that same cycle.
- R5: A tick that arrives while a scrub is in progress is held as a single pending tick, which starts the next scrub once the engine is idle. Any further ticks arriving in the same busy period are dropped.
- R6: No read or write strobe is given unless bus_gnt_i is high. With the grant withheld, the engine holds bus_req_o high and waits indefinitely.
- R7: From the read strobe until the write strobe, bus_req_o stays high without interruption.
- R8: A word carrying an upset holds its original data after it is scrubbed, and its upset is cleared by the write-back.
- R9: Without a tick, the engine keeps bus_req_o low and gives no memory strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scrub_tick_i | input | 1 | One-cycle request to scrub one word |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| mem_rd_o | output | 1 | Read strobe to the correcting read path |
| mem_wr_o | output | 1 | Write strobe to the encoding write path |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Data written back |
| mem_rdata_i | input | DATA_W | Corrected read data |
| mem_rvalid_i | input | 1 | Read data valid |
| pass_done_o | output | 1 | One-cycle pulse when the pointer wraps |
| pass_count_o | output | PASS_W | Number of completed passes |

## Verification
The hardest cases to reach are ticks that arrive while a scrub is in progress, and CPU contention that falls between a granted read and its write-back. The bench sends three ticks on consecutive cycles, so the second and third land while the engine is still requesting the bus. It then expects exactly two scrubs. The bench arbiter model raises CPU demand on a repeating pattern, which hits every state of the engine. The bench also withholds the grant outright for a long stretch to show that the engine holds its request and gives no strobes. Upsets are injected into the memory model, which lets the bench watch them get cleared on the wrap pass.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_REQ_READ   = 2'd1,
        ST_WAIT_DATA  = 2'd2,
        ST_WRITE_BACK = 2'd3
    } scrub_state_e;

endpackage

// File: rtl/scrub_tick_latch.sv
module scrub_tick_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ready_i,
    output logic go_o
);

    typedef struct packed {
        logic pending;
    } latch_regs_t;

    latch_regs_t r_q, r_d;

    always_comb begin
        r_d  = r_q;
        go_o = ready_i && (tick_i || r_q.pending);
        if (ready_i) begin
            // one request is consumed; a simultaneous second one stays held
            r_d.pending = r_q.pending && tick_i;
        end else begin
            // saturating: extra ticks while busy collapse into one
            r_d.pending = r_q.pending || tick_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R5: a held tick is served as soon as the engine is idle again
    assert_pending_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && r_q.pending) |-> go_o);

endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
    parameter int ADDR_W    = 6,
    parameter int REGION_LO = 4,
    parameter int REGION_HI = 13,
    parameter int PASS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              pass_done_o,
    output logic [PASS_W-1:0] pass_count_o
);

    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(REGION_LO);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(REGION_HI);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              done;
        logic [PASS_W-1:0] count;
    } addr_regs_t;

    addr_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (advance_i) begin
            if (r_q.ptr == HI_ADDR) begin
                r_d.ptr   = LO_ADDR;
                r_d.done  = 1'b1;
                r_d.count = r_q.count + 1'b1;
            end else begin
                r_d.ptr = r_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ptr   <= LO_ADDR;
            r_q.done  <= 1'b0;
            r_q.count <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ptr_o        = r_q.ptr;
    assign pass_done_o  = r_q.done;
    assign pass_count_o = r_q.count;

    assert_ptr_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_o >= LO_ADDR) && (ptr_o <= HI_ADDR));

    assert_wrap_to_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done_o |-> (ptr_o == LO_ADDR));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done_o |=> !pass_done_o);

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              gnt_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              rvalid_i,
    output logic              ready_o,
    output logic              req_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              advance_o
);

    typedef struct packed {
        scrub_state_e      state;
        logic [DATA_W-1:0] data;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        ready_o   = 1'b0;
        req_o     = 1'b0;
        rd_o      = 1'b0;
        wr_o      = 1'b0;
        advance_o = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                ready_o = 1'b1;
                if (go_i) r_d.state = ST_REQ_READ;
            end
            ST_REQ_READ: begin
                req_o = 1'b1;
                if (gnt_i) begin
                    rd_o      = 1'b1;
                    r_d.state = ST_WAIT_DATA;
                end
            end
            ST_WAIT_DATA: begin
                req_o = 1'b1;
                if (rvalid_i) begin
                    r_d.data  = rdata_i;
                    r_d.state = ST_WRITE_BACK;
                end
            end
            ST_WRITE_BACK: begin
                req_o = 1'b1;
                if (gnt_i) begin
                    wr_o      = 1'b1;
                    advance_o = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o  = ptr_i;
    assign wdata_o = r_q.data;

    // R7: once the read has been issued the request is not dropped before the write-back
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !wr_o) |=> req_o);

    // R2: the pointer does not move between a read and its write-back
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> $stable(addr_o));

endmodule

// File: rtl/mem_scrub_engine.sv
module mem_scrub_engine #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 8,
    parameter int REGION_LO = 4,
    parameter int REGION_HI = 13,
    parameter int PASS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scrub_tick_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              pass_done_o,
    output logic [PASS_W-1:0] pass_count_o
);

    logic              ready;
    logic              go;
    logic              advance;
    logic [ADDR_W-1:0] ptr;

    scrub_tick_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (scrub_tick_i),
        .ready_i (ready),
        .go_o    (go)
    );

    scrub_addr_gen #(
        .ADDR_W    (ADDR_W),
        .REGION_LO (REGION_LO),
        .REGION_HI (REGION_HI),
        .PASS_W    (PASS_W)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance_i    (advance),
        .ptr_o        (ptr),
        .pass_done_o  (pass_done_o),
        .pass_count_o (pass_count_o)
    );

    scrub_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .ptr_i     (ptr),
        .gnt_i     (bus_gnt_i),
        .rdata_i   (mem_rdata_i),
        .rvalid_i  (mem_rvalid_i),
        .ready_o   (ready),
        .req_o     (bus_req_o),
        .rd_o      (mem_rd_o),
        .wr_o      (mem_wr_o),
        .addr_o    (mem_addr_o),
        .wdata_o   (mem_wdata_o),
        .advance_o (advance)
    );

    // checker state: what the last read asked for and got back
    logic [ADDR_W-1:0] chk_rd_addr_q;
    logic [DATA_W-1:0] chk_rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_rd_addr_q <= '0;
            chk_rdata_q   <= '0;
        end else begin
            if (mem_rd_o)     chk_rd_addr_q <= mem_addr_o;
            if (mem_rvalid_i) chk_rdata_q   <= mem_rdata_i;
        end
    end

    assert_wb_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_addr_o == chk_rd_addr_q));

    assert_wb_same_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> (mem_wdata_o == chk_rdata_q));

    assert_strobe_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (bus_gnt_i && bus_req_o));

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

endmodule

// File: tb/sim_mem_scrub_engine.sv
module sim_mem_scrub_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int LO = 4;
    localparam int HI = 13;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          bus_req, bus_gnt, mem_rd, mem_wr, rvalid, pass_done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] wdata, rdata;
    logic [PW-1:0] pass_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_scrub_engine #(.ADDR_W(AW), .DATA_W(DW), .REGION_LO(LO), .REGION_HI(HI), .PASS_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .scrub_tick_i(tick),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_rvalid_i(rvalid),
        .pass_done_o(pass_done), .pass_count_o(pass_count)
    );

    // ---------------- arbiter model: CPU wins unless the engine already owns the bus
    logic       cpu_hold = 1'b0;
    logic       cpu_auto = 1'b0;
    logic [3:0] cyc;
    logic       owned;
    logic       cpu_want;

    assign cpu_want = cpu_hold || (cpu_auto && cyc[0] && cyc[2]);
    assign bus_gnt  = bus_req && (owned || !cpu_want);

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc   <= '0;
            owned <= 1'b0;
        end else begin
            cyc   <= cyc + 1'b1;
            owned <= bus_gnt;
        end
    end

    // ---------------- memory model: corrected read with two cycles latency, upset flags
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          err [0:(1<<AW)-1];
    logic          rv1;
    logic [AW-1:0] a1;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < (1<<AW); i++) begin
                mem[i] <= DW'(i*37+5);
                err[i] <= 1'b0;
            end
            rv1    <= 1'b0;
            a1     <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rv1    <= mem_rd;
            a1     <= mem_addr;
            rvalid <= rv1;
            rdata  <= mem[a1];
            if (mem_wr) begin
                mem[mem_addr] <= wdata;
                err[mem_addr] <= 1'b0;
            end
            if (inj_en) err[inj_addr] <= 1'b1;
        end
    end

    // ---------------- scoreboard
    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int exp_ptr = LO;
    logic [AW+DW-1:0] exp_q [$];
    bit in_pair = 0;
    bit gap = 0;
    bit prev_end = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_expect();
        exp_q.push_back({AW'(exp_ptr), mem[exp_ptr]});
        exp_ptr = (exp_ptr == HI) ? LO : exp_ptr + 1;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                check(bus_gnt, "R6 read without grant", int'(bus_gnt), 1);
                in_pair = 1;
                gap = 0;
            end
            if (in_pair && !bus_req) gap = 1;
            if (prev_end || pass_done)
                check(pass_done == prev_end, "R4 pass pulse", int'(pass_done), int'(prev_end));
            prev_end = mem_wr && (mem_addr == AW'(HI));
            if (mem_wr) begin
                check(!gap, "R7 request dropped inside pair", int'(gap), 0);
                in_pair = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected write-back", int'(mem_addr), -1);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(mem_addr == e[AW+DW-1:DW], "R3 scrub address", int'(mem_addr), int'(e[AW+DW-1:DW]));
                    check(wdata == e[DW-1:0], "R2 write-back data", int'(wdata), int'(e[DW-1:0]));
                end
                wr_count++;
            end
        end
    end

    task automatic wait_writes(input int target);
        while (wr_count < target) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- stimulus
    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!bus_req && !mem_rd && !mem_wr, "R1 bus idle after reset", int'(bus_req), 0);
        check(pass_count == 0 && !pass_done, "R1 pass counter after reset", int'(pass_count), 0);

        // R9: no tick, no activity
        repeat (10) @(negedge clk);
        check(wr_count == 0 && !bus_req, "R9 quiet without tick", wr_count, 0);

        // single tick: first address is the window base (R1, R2)
        push_expect();
        pulse_tick();
        wait_writes(1);
        check(exp_q.size() == 0, "R2 single tick single scrub", exp_q.size(), 0);

        // upset injection into the next word, then a full pass with CPU contention
        @(negedge clk) begin inj_en = 1'b1; inj_addr = AW'(LO+1); end
        @(negedge clk) inj_en = 1'b0;
        @(negedge clk);
        check(err[LO+1] == 1'b1, "R8 upset present before scrub", int'(err[LO+1]), 1);
        cpu_auto = 1'b1;
        for (int i = 0; i < 11; i++) begin
            push_expect();
            pulse_tick();
            wait_writes(wr_count + 1);
        end
        cpu_auto = 1'b0;
        check(pass_count == 1, "R4 pass count after wrap", int'(pass_count), 1);
        check(err[LO+1] == 1'b0, "R8 upset cleared", int'(err[LO+1]), 0);
        check(mem[LO+1] == DW'((LO+1)*37+5), "R8 data preserved", int'(mem[LO+1]), (LO+1)*37+5);

        // R5: three ticks on consecutive cycles give exactly two scrubs
        base = wr_count;
        push_expect();
        push_expect();
        @(negedge clk) tick = 1'b1;
        repeat (3) @(negedge clk);
        tick = 1'b0;
        repeat (40) @(negedge clk);
        check(wr_count - base == 2, "R5 ticks coalesced", wr_count - base, 2);

        // R6: grant withheld, engine waits with request high
        base = wr_count;
        cpu_hold = 1'b1;
        push_expect();
        pulse_tick();
        repeat (20) @(negedge clk);
        check(bus_req && !mem_rd, "R6 waiting for grant", int'(bus_req), 1);
        check(wr_count == base, "R6 no scrub without grant", wr_count - base, 0);
        cpu_hold = 1'b0;
        wait_writes(base + 1);
        check(wr_count - base == 1, "R6 scrub after release", wr_count - base, 1);

        // R9 again: no further activity
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && !bus_req, "R9 nothing left over", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wr_count, -1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule